// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block holds two capture/compare channels that share one free-running up-counter. Each channel has a small control register and a value register. The control register holds a two-bit edge/level field and one mode bit. Channel 0 also has a bit that turns the pair into one buffered compare output. A channel can timestamp edges on its pin, which is input capture. It can also change its pin when the counter reaches a programmed value, which is output compare. With the edge/level field cleared, the channel gives its pin back to general-purpose I/O. In that case the mode bit only sets the level the pin will start from.

Software reaches the registers through a simple synchronous write port and a combinational read port. The counter is started, stopped and cleared by two control inputs. The `pin_own` outputs tell the pad logic which channel pins the block is currently driving.

In buffered mode the two value registers take turns as the compare target, one after each match. Software can reload the idle register while the other one is active. Only channel 0's pin carries the result, and channel 1 is switched off for that time.

Top module: `tmr_ccpair`

## Requirements
- R1: After reset, every control field, value register and flag is zero, the counter is zero, neither pin is owned, and both `cmp_out` levels are high.
- R2: Register address 0 is channel 0 control, 1 is channel 0 value, 2 is channel 1 control and 3 is channel 1 value. Control bit 0 is the buffered bit (channel 0 only; it is dropped on channel 1 and reads 0 there), bit 1 is the mode bit, bits 3:2 are the edge/level field and bit 4 is the flag.
- R3: With the edge/level field at 00 the channel does not own its pin. The pin level becomes the inverse of the mode bit one edge after the control register shows it: mode bit 1 gives low, 0 gives high.
- R4: With a nonzero edge/level field and mode bit 0 the channel captures. Field 01 reacts to rising pin edges, 10 to falling edges and 11 to both. On the clock edge that sees the pin edge, the counter's present value goes into the value register and the flag sets. The pin is not owned.
- R5: With a nonzero field and mode bit 1 the channel compares and owns its pin. At the clock edge where the running counter equals the value register, the flag sets and the pin toggles (01), goes low (10) or goes high (11).
- R6: No compare match occurs while the counter is stopped, even when it equals the value register.
- R7: Asserting `cnt_clr` zeroes the counter at the next edge. Otherwise, while `cnt_run` is high, the counter increments by one on each edge.
- R8: With channel 0's buffered bit set and a nonzero field, channel 0 compares first against value register 0 and then against value register 1, alternating after each match. Every match acts on channel 0's pin and sets flag 0. A counter clear restarts the sequence with register 0.
- R9: While the buffered bit is set, writes to address 2 are ignored and address 2 reads 0. Channel 1 neither captures nor compares, and its pin is not owned. Value register 1 stays writable, and channel 1's earlier control returns when buffering ends.
- R10: Writing a control register with bit 4 set clears that channel's flag. A flag-setting event in the same cycle wins over the clear.
- R11: Control writes take effect even while the counter is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_run | input | 1 | Counter advances while high |
| cnt_clr | input | 1 | Synchronous counter clear (wins over run) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` (combinational) |
| cap_in | input | 2 | Channel pin inputs, index = channel |
| cmp_out | output | 2 | Channel pin output levels |
| pin_own | output | 2 | 1 when the block drives that channel pin |
| chan_flag | output | 2 | Channel event flags |
| cnt_value | output | CNT_W | Shared counter value |

## Verification
A register write shows up on the read port and in `pin_own` right after the edge that takes the write. An idle pin level follows one edge later. A capture result and its flag can be read after the edge that sees the pin edge, or later when synchroniser stages are configured. A compare action shows up after the edge where the counter moves past the matching value. The bench drives inputs and samples all outputs at the falling clock edge. It keeps its own counter model stepped from the same run and clear inputs, so each expected capture value is the model's count just before the sampling edge. The bench waits for the model to reach a compare value before taking the edge that must produce the match. Random capture traffic on channel 0 is checked every cycle against a bench edge detector for each field setting.

// File: rtl/tmr_ccpair_pkg.sv
package tmr_ccpair_pkg;

   // Control register layout, LSB first: buffered bit, mode bit, edge/level field.
   typedef struct packed {
      logic [1:0] els;
      logic       mode_a;
      logic       mode_b;
   } chan_ctrl_t;

   typedef enum logic [2:0] {
      CM_OFF,
      CM_IDLE,
      CM_CAPTURE,
      CM_COMPARE,
      CM_BUFFERED
   } chan_mode_e;

   localparam logic [1:0] ELS_NONE = 2'b00;
   localparam logic [1:0] ELS_A    = 2'b01;   // rising / toggle
   localparam logic [1:0] ELS_B    = 2'b10;   // falling / clear
   localparam logic [1:0] ELS_AB   = 2'b11;   // both / set

endpackage

// File: rtl/tmr_ccpair_cnt.sv
module tmr_ccpair_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else if (run) count <= count + 1'b1;
   end

endmodule

// File: rtl/tmr_ccpair_chan.sv
module tmr_ccpair_chan
   import tmr_ccpair_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       els,
   input  logic             mode_a,
   input  logic             disabled,
   input  logic             buf_master,
   input  logic             cnt_run,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic             pin_in,
   output logic             cap_evt,
   output logic             match_evt,
   output logic             pin_level,
   output logic             pin_drive
);

   chan_mode_e mode;
   logic       pin_s;
   logic       pin_prev;
   logic       pin_q;
   logic       rise;
   logic       fall;

   // Optional input synchroniser chosen by parameter
   if (SYNC_STAGES == 0) begin : g_nosync
      assign pin_s = pin_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh <= '0;
         end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) sh[i] <= sh[i-1];
            sh[0] <= pin_in;
         end
      end
      assign pin_s = sh[SYNC_STAGES-1];
   end

   always_comb begin
      if (disabled)              mode = CM_OFF;
      else if (els == ELS_NONE)  mode = CM_IDLE;
      else if (buf_master)       mode = CM_BUFFERED;
      else if (mode_a)           mode = CM_COMPARE;
      else                       mode = CM_CAPTURE;
   end

   assign rise      = pin_s & ~pin_prev;
   assign fall      = ~pin_s & pin_prev;
   assign cap_evt   = (mode == CM_CAPTURE) && ((els[0] && rise) || (els[1] && fall));
   assign pin_drive = (mode == CM_COMPARE) || (mode == CM_BUFFERED);
   assign match_evt = pin_drive && cnt_run && (cnt == cmp_val);
   assign pin_level = pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_prev <= 1'b0;
         pin_q    <= 1'b1;
      end else begin
         pin_prev <= pin_s;
         if (mode == CM_IDLE) begin
            pin_q <= ~mode_a;
         end else if (match_evt) begin
            case (els)
               ELS_A:   pin_q <= ~pin_q;
               ELS_B:   pin_q <= 1'b0;
               ELS_AB:  pin_q <= 1'b1;
               default: pin_q <= pin_q;
            endcase
         end
      end
   end

endmodule

// File: rtl/tmr_ccpair.sv
module tmr_ccpair
   import tmr_ccpair_pkg::*;
#(
   parameter int unsigned CNT_W           = 16,
   parameter int unsigned CAP_SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_run,
   input  logic             cnt_clr,
   input  logic             bus_we,
   input  logic [1:0]       bus_addr,
   input  logic [CNT_W-1:0] bus_wdata,
   output logic [CNT_W-1:0] bus_rdata,
   input  logic [1:0]       cap_in,
   output logic [1:0]       cmp_out,
   output logic [1:0]       pin_own,
   output logic [1:0]       chan_flag,
   output logic [CNT_W-1:0] cnt_value
);

   localparam int unsigned NCH    = 2;
   localparam int unsigned ADDR_W = $clog2(2 * NCH);
   localparam int unsigned CTRL_W = $bits(chan_ctrl_t);
   localparam int unsigned FLAG_B = CTRL_W;

   if (CNT_W < CTRL_W + 1 || CNT_W > 32) begin : g_bad_width
      $error("tmr_ccpair: CNT_W out of range");
   end
   if (CAP_SYNC_STAGES > 3) begin : g_bad_sync
      $error("tmr_ccpair: CAP_SYNC_STAGES must be 0 to 3");
   end

   chan_ctrl_t       ctrl_q [NCH];
   logic [CNT_W-1:0] val_q  [NCH];
   logic [CNT_W-1:0] cmp_val[NCH];
   logic [NCH-1:0]   flag_q;
   logic [NCH-1:0]   we_ctrl;
   logic [NCH-1:0]   we_val;
   logic [NCH-1:0]   chan_off;
   logic [NCH-1:0]   cap_evt;
   logic [NCH-1:0]   match_evt;
   logic [1:0]       els_v [NCH];
   logic             buf_mode;
   logic             buf_sel;

   assign buf_mode = ctrl_q[0].mode_b;

   tmr_ccpair_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (cnt_run),
      .clr  (cnt_clr),
      .count(cnt_value)
   );

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         chan_off[i] = (i != 0) && buf_mode;
         we_ctrl[i]  = bus_we && (bus_addr == ADDR_W'(2 * i)) && !chan_off[i];
         we_val[i]   = bus_we && (bus_addr == ADDR_W'(2 * i + 1));
      end
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam bit IS_LEAD = (g == 0);
      assign cmp_val[g] = (IS_LEAD && buf_mode && buf_sel) ? val_q[1] : val_q[g];
      assign els_v[g]   = ctrl_q[g].els;
      tmr_ccpair_chan #(.CNT_W(CNT_W), .SYNC_STAGES(CAP_SYNC_STAGES)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .els       (ctrl_q[g].els),
         .mode_a    (ctrl_q[g].mode_a),
         .disabled  (chan_off[g]),
         .buf_master(IS_LEAD ? buf_mode : 1'b0),
         .cnt_run   (cnt_run),
         .cnt       (cnt_value),
         .cmp_val   (cmp_val[g]),
         .pin_in    (cap_in[g]),
         .cap_evt   (cap_evt[g]),
         .match_evt (match_evt[g]),
         .pin_level (cmp_out[g]),
         .pin_drive (pin_own[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            ctrl_q[i] <= '0;
            val_q[i]  <= '0;
         end
         flag_q  <= '0;
         buf_sel <= 1'b0;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            if (we_ctrl[i]) begin
               ctrl_q[i] <= chan_ctrl_t'(bus_wdata[CTRL_W-1:0]);
               if (i != 0) ctrl_q[i].mode_b <= 1'b0;
            end
            if (cap_evt[i])     val_q[i] <= cnt_value;
            else if (we_val[i]) val_q[i] <= bus_wdata;
            if (cap_evt[i] || match_evt[i])           flag_q[i] <= 1'b1;
            else if (we_ctrl[i] && bus_wdata[FLAG_B]) flag_q[i] <= 1'b0;
         end
         if (!buf_mode || cnt_clr) buf_sel <= 1'b0;
         else if (match_evt[0])    buf_sel <= ~buf_sel;
      end
   end

   assign chan_flag = flag_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         2'd0: bus_rdata[CTRL_W:0] = {flag_q[0], ctrl_q[0]};
         2'd1: bus_rdata = val_q[0];
         2'd2: if (!buf_mode) bus_rdata[CTRL_W:0] = {flag_q[1], ctrl_q[1]};
         default: bus_rdata = val_q[1];
      endcase
   end

endmodule

// File: rtl/tmr_ccpair_chk.sv
module tmr_ccpair_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_run,
   input logic             cnt_clr,
   input logic [CNT_W-1:0] cnt_value,
   input logic [1:0]       cmp_out,
   input logic [1:0]       pin_own,
   input logic [1:0]       chan_flag,
   input logic [1:0]       cap_evt,
   input logic [1:0]       els0,
   input logic [1:0]       els1,
   input logic             buf_mode
);

   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> cnt_value == '0);  // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_run && !cnt_clr) |=> cnt_value == $past(cnt_value) + 1'b1);  // R7
   AST_IDLE_FREE0: assert property (@(posedge clk) disable iff (!rst_n)
      (els0 == 2'b00) |-> !pin_own[0]);  // R3
   AST_IDLE_FREE1: assert property (@(posedge clk) disable iff (!rst_n)
      (els1 == 2'b00) |-> !pin_own[1]);  // R3
   AST_CAP_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[0] |=> chan_flag[0]);  // R4
   AST_CAP_FLAG1: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[1] |=> chan_flag[1]);  // R4
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_run && pin_own[0]) |=> $stable(cmp_out[0]));  // R6
   AST_CH1_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      buf_mode |-> (!pin_own[1] && !cap_evt[1]));  // R9

endmodule

bind tmr_ccpair tmr_ccpair_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cnt_run  (cnt_run),
   .cnt_clr  (cnt_clr),
   .cnt_value(cnt_value),
   .cmp_out  (cmp_out),
   .pin_own  (pin_own),
   .chan_flag(chan_flag),
   .cap_evt  (cap_evt),
   .els0     (els_v[0]),
   .els1     (els_v[1]),
   .buf_mode (buf_mode)
);

// File: tb/tmr_ccpair_bench.sv
module tmr_ccpair_bench;

   localparam int unsigned CNT_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cnt_run = 1'b0;
   logic             cnt_clr = 1'b0;
   logic             bus_we = 1'b0;
   logic [1:0]       bus_addr = '0;
   logic [CNT_W-1:0] bus_wdata = '0;
   logic [CNT_W-1:0] bus_rdata;
   logic [1:0]       cap_in = '0;
   logic [1:0]       cmp_out;
   logic [1:0]       pin_own;
   logic [1:0]       chan_flag;
   logic [CNT_W-1:0] cnt_value;

   int               n_chk = 0;
   int               n_err = 0;
   logic [CNT_W-1:0] m_cnt = '0;
   logic             m_prev0 = 1'b0;

   always #5 clk = ~clk;

   tmr_ccpair #(.CNT_W(CNT_W), .CAP_SYNC_STAGES(0)) u_tmr_ccpair (
      .clk(clk), .rst_n(rst_n), .cnt_run(cnt_run), .cnt_clr(cnt_clr),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cap_in(cap_in), .cmp_out(cmp_out),
      .pin_own(pin_own), .chan_flag(chan_flag), .cnt_value(cnt_value)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // One clock: bench counter model follows the inputs held across the edge.
   task automatic cyc();
      if (cnt_clr)      m_cnt = '0;
      else if (cnt_run) m_cnt = m_cnt + 1'b1;
      m_prev0 = cap_in[0];
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic cap_expect(input logic [1:0] els, input logic now, input logic prev);
      return (els[0] && now && !prev) || (els[1] && !now && prev);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [CNT_W-1:0] rv;
      logic [CNT_W-1:0] exp_val;
      logic [CNT_W-1:0] target;
      logic             exp_flag;
      logic             now;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 cmp_out", 32'(cmp_out), 32'h3);
      chk("R1 pin_own", 32'(pin_own), 32'h0);
      chk("R1 flags", 32'(chan_flag), 32'h0);
      chk("R1 counter", 32'(cnt_value), 32'h0);
      rd(2'd0, rv); chk("R1 ctrl0", 32'(rv), 32'h0);
      rd(2'd3, rv); chk("R1 val1", 32'(rv), 32'h0);

      // R7 counter
      cnt_run = 1'b1;
      repeat (7) cyc();
      chk("R7 run count", 32'(cnt_value), 32'(m_cnt));
      cnt_run = 1'b0;
      repeat (3) cyc();
      chk("R7 hold count", 32'(cnt_value), 32'd7);
      cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0;
      chk("R7 clear", 32'(cnt_value), 32'h0);

      // R3 idle level, R2 readback
      wr(2'd0, 16'h0002);
      cyc();
      chk("R3 idle low", 32'(cmp_out[0]), 32'h0);
      chk("R3 not owned", 32'(pin_own[0]), 32'h0);
      rd(2'd0, rv); chk("R2 ctrl0 read", 32'(rv), 32'h2);
      wr(2'd0, 16'h0000);
      cyc();
      chk("R3 idle high", 32'(cmp_out[0]), 32'h1);
      wr(2'd2, 16'h000F);
      rd(2'd2, rv); chk("R2 ch1 drops buffered bit", 32'(rv), 32'hE);
      wr(2'd2, 16'h0000);

      // R4 directed rising capture on channel 1
      wr(2'd2, 16'h0004);
      cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0;
      cnt_run = 1'b1;
      repeat (5) cyc();
      cap_in[1] = 1'b1;
      exp_val = m_cnt;
      cyc();
      rd(2'd3, rv); chk("R4 rising capture value", 32'(rv), 32'(exp_val));
      chk("R4 capture flag", 32'(chan_flag[1]), 32'h1);
      chk("R4 capture not owned", 32'(pin_own[1]), 32'h0);
      repeat (3) cyc();
      cap_in[1] = 1'b0;
      repeat (2) cyc();
      rd(2'd3, rv); chk("R4 falling ignored", 32'(rv), 32'(exp_val));
      wr(2'd2, 16'h0014);
      chk("R10 flag clear", 32'(chan_flag[1]), 32'h0);

      // R4 random capture on channel 0, each edge setting
      exp_val = '0;
      for (int e = 1; e < 4; e++) begin
         wr(2'd0, CNT_W'((e << 2) | 16'h10));
         exp_flag = 1'b0;
         for (int k = 0; k < 40; k++) begin
            now = 1'($urandom % 2);
            cap_in[0] = now;
            if (cap_expect(2'(e), now, m_prev0)) begin
               exp_val = m_cnt;
               exp_flag = 1'b1;
            end
            cyc();
            rd(2'd1, rv);
            chk("R4 random capture value", 32'(rv), 32'(exp_val));
            chk("R4 random capture flag", 32'(chan_flag[0]), 32'(exp_flag));
         end
      end
      wr(2'd0, 16'h0010);
      cap_in[0] = 1'b0;
      cyc();

      // R5 toggle compare
      cnt_run = 1'b0;
      wr(2'd1, 16'd20);
      cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0;
      wr(2'd0, 16'h0006);
      chk("R5 compare owns pin", 32'(pin_own[0]), 32'h1);
      chk("R5 start level", 32'(cmp_out[0]), 32'h1);
      cnt_run = 1'b1;
      while (m_cnt != 16'd20) cyc();
      chk("R5 no early toggle", 32'(cmp_out[0]), 32'h1);
      cyc();
      chk("R5 toggle on match", 32'(cmp_out[0]), 32'h0);
      chk("R5 match flag", 32'(chan_flag[0]), 32'h1);

      // R5 set then clear actions
      cnt_run = 1'b0;
      target = m_cnt + 16'd5;
      wr(2'd1, target); wr(2'd0, 16'h001E);
      cnt_run = 1'b1;
      while (m_cnt != target) cyc();
      cyc();
      chk("R5 set on match", 32'(cmp_out[0]), 32'h1);
      cnt_run = 1'b0;
      target = m_cnt + 16'd5;
      wr(2'd1, target); wr(2'd0, 16'h001A);
      cnt_run = 1'b1;
      while (m_cnt != target) cyc();
      cyc();
      chk("R5 clear on match", 32'(cmp_out[0]), 32'h0);

      // R6 stopped counter never matches
      cnt_run = 1'b0;
      wr(2'd0, 16'h0016);
      wr(2'd1, m_cnt);
      repeat (4) cyc();
      chk("R6 no flag while stopped", 32'(chan_flag[0]), 32'h0);
      chk("R6 pin held while stopped", 32'(cmp_out[0]), 32'h0);
      cnt_run = 1'b1;
      cyc();
      chk("R6 match once running", 32'(cmp_out[0]), 32'h1);

      // R10 set wins over clear
      cnt_run = 1'b0;
      target = m_cnt + 16'd3;
      wr(2'd1, target); wr(2'd0, 16'h0016);
      cnt_run = 1'b1;
      while (m_cnt != target) cyc();
      wr(2'd0, 16'h0016);
      chk("R10 set beats clear", 32'(chan_flag[0]), 32'h1);
      chk("R10 toggle same edge", 32'(cmp_out[0]), 32'h0);

      // R8 buffered compare
      cnt_run = 1'b0;
      cnt_clr = 1'b1; cyc(); cnt_clr = 1'b0;
      wr(2'd0, 16'h0010);
      wr(2'd1, 16'd5);
      wr(2'd3, 16'd9);
      wr(2'd0, 16'h0015);
      chk("R8 lead pin owned", 32'(pin_own[0]), 32'h1);
      chk("R9 second pin released", 32'(pin_own[1]), 32'h0);
      cnt_run = 1'b1;
      while (m_cnt != 16'd5) cyc();
      cyc();
      chk("R8 first match from value 0", 32'(cmp_out[0]), 32'h0);
      chk("R8 flag0 on first match", 32'(chan_flag[0]), 32'h1);
      wr(2'd0, 16'h0015);
      while (m_cnt != 16'd9) cyc();
      chk("R8 flag cleared before second", 32'(chan_flag[0]), 32'h0);
      cyc();
      chk("R8 second match from value 1", 32'(cmp_out[0]), 32'h1);
      chk("R8 flag0 on second match", 32'(chan_flag[0]), 32'h1);
      chk("R8 flag1 untouched", 32'(chan_flag[1]), 32'h0);

      // R9 channel 1 disabled while buffered
      wr(2'd2, 16'h0006);
      rd(2'd2, rv); chk("R9 ctrl1 reads zero", 32'(rv), 32'h0);
      chk("R9 write ignored pin", 32'(pin_own[1]), 32'h0);
      cap_in[1] = 1'b1;
      repeat (2) cyc();
      rd(2'd3, rv); chk("R9 no capture", 32'(rv), 32'd9);
      chk("R9 no ch1 flag", 32'(chan_flag[1]), 32'h0);
      cnt_run = 1'b0;
      wr(2'd0, 16'h0010);
      rd(2'd2, rv); chk("R9 old ctrl1 returns", 32'(rv), 32'h4);

      // R11 mode write while running
      cnt_run = 1'b1;
      wr(2'd2, 16'h0006);
      chk("R11 write while running", 32'(pin_own[1]), 32'h1);
      rd(2'd2, rv); chk("R11 ctrl1 readback", 32'(rv), 32'h6);
      cnt_run = 1'b0;
      cyc();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule